// File: doc/BRIEF.md
# Linked-List DMA Walker

This engine moves command data between a word-addressed memory and a graphics command port without help from the processor. It has two modes. In walk mode it follows a chain of packets. Each packet starts with a header word that holds a payload length and a pointer to the next header. The engine sends every payload word, in order, out on a valid/ready stream. In clear mode it builds an empty ordering table. It writes a backward-linked chain of zero-length headers, one word per entry, stepping down through memory.

Software loads a start address, a mode bit and, for clear mode, an entry count, then pulses start. Busy stays high until the chain ends or the table is written. An optional chopping control splits the memory traffic into windows of 2^N words, each followed by 2^M idle cycles, so that other masters can reach the bus.

Top module: `lldma_walker`

## Requirements
- R1: After reset, busy, mem_req and out_valid are all low.
- R2: Walk mode reads the header at the start address. Bits 31:24 of the header are a payload count L and bits 23:0 are the next header address. The engine reads the L words at header+4, header+8, and so on, sends them on out_data in that order, and then reads the header at the next address.
- R3: A header whose bits 23:0 are 0xFFFFFF ends the walk. Nothing from that header is sent, and busy falls once the last payload word has left.
- R4: A header with count 0 sends no word. The engine only moves on to its next address.
- R5: While out_valid is high and out_ready is low, out_valid and out_data hold steady, and no payload word is read from memory.
- R6: Clear mode with count n > 0 and address A writes n words at A, A-4, ..., A-4(n-1). Each word holds the address of the entry written after it, with bits 31:24 zero. The last word holds 0x00FFFFFF. A count of 0 writes nothing, and no word outside the range is changed.
- R7: With mem_ack and out_ready held high and chopping off, one memory word moves per clock. Busy is high for exactly as many cycles as words are read or written.
- R8: With chopping on, after every 2^N completed memory words (N = chop_win_log), mem_req stays low for 2^M cycles (M = chop_gap_log), and then traffic resumes.
- R9: A start pulse while busy is ignored. An accepted walk start raises busy on the next cycle.
- R10: Walk mode never writes memory, and clear mode never raises out_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle start pulse, taken only while idle |
| mode_clear | input | 1 | 0 = walk a packet chain, 1 = build an empty table |
| start_addr | input | 24 | Byte address of the first header (walk) or of the highest entry (clear) |
| clear_count | input | CNT_W | Number of table entries in clear mode |
| chop_en | input | 1 | Enables windowed bus use |
| chop_win_log | input | CHOP_W | log2 of the words per window |
| chop_gap_log | input | CHOP_W | log2 of the idle cycles between windows |
| busy | output | 1 | High while a transfer is in progress |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 24 | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | A word moves in a cycle where mem_req and mem_ack are both high |
| mem_rdata | input | 32 | Read data, valid in the cycle of the ack |
| out_valid | output | 1 | Payload word available |
| out_data | output | 32 | Payload word |
| out_ready | input | 1 | Consumer accepts the word |

## Verification
The bench builds the block with its defaults: a 16-bit clear count and 3-bit chop exponents, so windows and gaps can each reach 128. It drives exponents of 0 to 2, which makes several window and gap cycles occur inside chains of only a few dozen words. A 256-word model memory holds shuffled chains of up to a dozen packets, each with up to 7 payload words, together with clear tables that sit between two sentinel words. Randomly thinned ack and ready signals then open every stall path of the output register and the request logic.

// File: rtl/lldma_pkg.sv
`timescale 1ns/1ps
package lldma_pkg;
    localparam int LEN_W  = 8;
    localparam int PTR_W  = 24;
    localparam int WORD_W = LEN_W + PTR_W;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HDR  = 2'd1,
        ST_PAY  = 2'd2,
        ST_CLR  = 2'd3
    } st_e;
endpackage

// File: rtl/lldma_chop.sv
`timescale 1ns/1ps
// Bus window pacing: after 2^win_log completed words, holds off requests
// for 2^gap_log cycles.
module lldma_chop #(
    parameter int CHOP_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              en,
    input  logic [CHOP_W-1:0] win_log,
    input  logic [CHOP_W-1:0] gap_log,
    input  logic              beat,
    output logic              hold
);
    localparam int CW = 1 << CHOP_W;
    localparam logic [CW-1:0] ONE = CW'(1);

    typedef struct packed {
        logic          gap;
        logic [CW-1:0] words;
        logic [CW-1:0] ticks;
    } chop_t;

    chop_t q, d;
    logic [CW-1:0] win_last, gap_last;

    always_comb begin
        win_last = (ONE << win_log) - ONE;
        gap_last = (ONE << gap_log) - ONE;
        d = q;
        if (restart) begin
            d = '0;
        end else if (q.gap) begin
            if (q.ticks == gap_last) begin
                d.gap   = 1'b0;
                d.ticks = '0;
            end else begin
                d.ticks = q.ticks + ONE;
            end
        end else if (en && beat) begin
            if (q.words == win_last) begin
                d.gap   = 1'b1;
                d.words = '0;
            end else begin
                d.words = q.words + ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign hold = q.gap;
endmodule

// File: rtl/lldma_outbuf.sv
`timescale 1ns/1ps
// One-entry output register; accepts a new word in the cycle it drains.
module lldma_outbuf #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] din,
    input  logic         ready,
    output logic         valid,
    output logic [W-1:0] dout,
    output logic         room
);
    typedef struct packed {
        logic         v;
        logic [W-1:0] data;
    } ob_t;

    ob_t q, d;

    always_comb begin
        d = q;
        if (load) begin
            d.v    = 1'b1;
            d.data = din;
        end else if (ready) begin
            d.v = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign valid = q.v;
    assign dout  = q.data;
    assign room  = !q.v || ready;
endmodule

// File: rtl/lldma_walker.sv
`timescale 1ns/1ps
module lldma_walker
    import lldma_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int CHOP_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              mode_clear,
    input  logic [23:0]       start_addr,
    input  logic [CNT_W-1:0]  clear_count,
    input  logic              chop_en,
    input  logic [CHOP_W-1:0] chop_win_log,
    input  logic [CHOP_W-1:0] chop_gap_log,
    output logic              busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic [23:0]       mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    output logic              out_valid,
    output logic [31:0]       out_data,
    input  logic              out_ready
);
    localparam logic [PTR_W-1:0] END_PTR = '1;
    localparam logic [PTR_W-1:0] STEP    = PTR_W'(4);
    localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        st_e              st;
        logic [PTR_W-1:0] cur;   // header address (walk) / write address (clear)
        logic [PTR_W-1:0] nxt;   // next header pointer of current packet
        logic [PTR_W-1:0] rd;    // payload read address
        logic [LEN_W-1:0] left;  // payload words still to read
        logic [CNT_W-1:0] cnt;   // table entries still to write
    } regs_t;

    regs_t q, d;

    logic             chop_hold;
    logic             ob_room;
    logic             beat;
    logic             accept;
    logic             in_pay;
    logic             in_clr;
    logic             load_word;
    logic [LEN_W-1:0] hdr_len;
    logic [PTR_W-1:0] hdr_ptr;

    assign hdr_len = mem_rdata[WORD_W-1:PTR_W];
    assign hdr_ptr = mem_rdata[PTR_W-1:0];
    assign in_pay  = (q.st == ST_PAY);
    assign in_clr  = (q.st == ST_CLR);
    assign busy    = (q.st != ST_IDLE) || out_valid;
    assign accept  = start && !busy;

    // Memory port
    always_comb begin
        mem_req = !chop_hold &&
                  ((q.st == ST_HDR) || in_clr || (in_pay && ob_room));
        mem_we  = in_clr;
        mem_addr = in_pay ? q.rd : q.cur;
        mem_wdata = {{LEN_W{1'b0}},
                     (q.cnt == CNT_ONE) ? END_PTR : (q.cur - STEP)};
    end

    assign beat      = mem_req && mem_ack;
    assign load_word = in_pay && beat;

    // Next-state
    always_comb begin
        d = q;
        unique case (q.st)
            ST_IDLE: begin
                if (accept) begin
                    if (mode_clear) begin
                        if (clear_count != '0) begin
                            d.st  = ST_CLR;
                            d.cur = start_addr;
                            d.cnt = clear_count;
                        end
                    end else begin
                        d.st  = ST_HDR;
                        d.cur = start_addr;
                    end
                end
            end
            ST_HDR: begin
                if (beat) begin
                    if (hdr_ptr == END_PTR) begin
                        d.st = ST_IDLE;
                    end else if (hdr_len == '0) begin
                        d.cur = hdr_ptr;
                    end else begin
                        d.st   = ST_PAY;
                        d.left = hdr_len;
                        d.nxt  = hdr_ptr;
                        d.rd   = q.cur + STEP;
                    end
                end
            end
            ST_PAY: begin
                if (beat) begin
                    if (q.left == LEN_ONE) begin
                        d.st  = ST_HDR;
                        d.cur = q.nxt;
                    end else begin
                        d.left = q.left - LEN_ONE;
                        d.rd   = q.rd + STEP;
                    end
                end
            end
            ST_CLR: begin
                if (beat) begin
                    if (q.cnt == CNT_ONE) begin
                        d.st = ST_IDLE;
                    end else begin
                        d.cnt = q.cnt - CNT_ONE;
                        d.cur = q.cur - STEP;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    lldma_chop #(.CHOP_W(CHOP_W)) u_chop (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (accept),
        .en      (chop_en),
        .win_log (chop_win_log),
        .gap_log (chop_gap_log),
        .beat    (beat),
        .hold    (chop_hold)
    );

    lldma_outbuf #(.W(WORD_W)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load_word),
        .din   (mem_rdata),
        .ready (out_ready),
        .valid (out_valid),
        .dout  (out_data),
        .room  (ob_room)
    );
endmodule

// File: rtl/lldma_walker_chk.sv
`timescale 1ns/1ps
module lldma_walker_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        mode_clear,
    input logic        busy,
    input logic        mem_req,
    input logic        mem_we,
    input logic        out_valid,
    input logic        out_ready,
    input logic [31:0] out_data,
    input logic        in_pay,
    input logic        in_clr,
    input logic        chop_hold
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!busy && !mem_req && !out_valid));

    assert_out_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    assert_no_pay_read_waiting_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_pay && out_valid && !out_ready) |-> !mem_req);

    assert_gap_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        chop_hold |-> !mem_req);

    assert_idle_no_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

    assert_start_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !mode_clear) |=> busy);

    assert_no_write_with_output_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && mem_req && mem_we));

    assert_clear_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_clr |-> !out_valid);
endmodule

bind lldma_walker lldma_walker_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .mode_clear (mode_clear),
    .busy       (busy),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data),
    .in_pay     (in_pay),
    .in_clr     (in_clr),
    .chop_hold  (chop_hold)
);

// File: tb/lldma_walker_tb.sv
`timescale 1ns/1ps
module lldma_walker_tb;
    localparam int CNT_W  = 16;
    localparam int CHOP_W = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic              mode_clear = 1'b0;
    logic [23:0]       start_addr = '0;
    logic [CNT_W-1:0]  clear_count = '0;
    logic              chop_en = 1'b0;
    logic [CHOP_W-1:0] chop_win_log = '0;
    logic [CHOP_W-1:0] chop_gap_log = '0;
    logic              busy, mem_req, mem_we, out_valid;
    logic [23:0]       mem_addr;
    logic [31:0]       mem_wdata, mem_rdata, out_data;
    logic              mem_ack = 1'b0;
    logic              out_ready = 1'b0;

    always #2.5 clk = ~clk;

    lldma_walker #(.CNT_W(CNT_W), .CHOP_W(CHOP_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode_clear(mode_clear),
        .start_addr(start_addr), .clear_count(clear_count), .chop_en(chop_en),
        .chop_win_log(chop_win_log), .chop_gap_log(chop_gap_log), .busy(busy),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready)
    );

    logic [31:0] mem  [256];
    logic [31:0] snap [256];
    bit          is_pay [256];
    assign mem_rdata = mem[mem_addr[9:2]];

    int          n_tests = 0;
    int          n_fail = 0;
    int          ack_pct = 100;
    int          rdy_pct = 100;
    int          busy_cycles = 0;
    int          pay_viol = 0;
    logic [31:0] got_q[$];
    logic [31:0] exp_q[$];

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Bus model and monitor: drive at the falling edge, observe what the next rising edge sees.
    always @(negedge clk) begin
        mem_ack   = ($urandom_range(99) < ack_pct);
        out_ready = ($urandom_range(99) < rdy_pct);
        #1;
        if (rst_n) begin
            if (busy) busy_cycles++;
            if (out_valid && out_ready) got_q.push_back(out_data);
            if (out_valid && !out_ready && mem_req && !mem_we && is_pay[mem_addr[9:2]])
                pay_viol++;
            if (mem_req && mem_ack && mem_we) mem[mem_addr[9:2]] = mem_wdata;
        end
    end

    task automatic kick(input bit clr, input logic [23:0] a, input logic [CNT_W-1:0] n);
        @(negedge clk);
        start = 1'b1; mode_clear = clr; start_addr = a; clear_count = n;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle();
        do begin
            @(negedge clk); #2;
        end while (busy);
    endtask

    task automatic fill_random();
        for (int i = 0; i < 256; i++) begin
            mem[i] = $urandom; is_pay[i] = 1'b0;
        end
    endtask

    task automatic take_snap();
        for (int i = 0; i < 256; i++) snap[i] = mem[i];
    endtask

    function automatic int mem_changes();
        int c = 0;
        for (int i = 0; i < 256; i++) if (mem[i] !== snap[i]) c++;
        return c;
    endfunction

    // Chain of npk packets in shuffled 8-word slots; a terminator in slot npk.
    task automatic build_chain(input int npk, input int minlen, input int maxlen,
                               output logic [23:0] head, output int beats);
        int slots[16];
        for (int i = 0; i < 16; i++) slots[i] = i;
        for (int i = 15; i > 0; i--) begin
            int j = $urandom_range(i);
            int t = slots[i]; slots[i] = slots[j]; slots[j] = t;
        end
        fill_random();
        exp_q.delete();
        beats = npk + 1;
        for (int p = 0; p < npk; p++) begin
            int base = slots[p] * 8;
            int len = $urandom_range(maxlen, minlen);
            logic [23:0] nx = 24'(slots[p+1] * 32);
            mem[base] = {8'(len), nx};
            for (int k = 1; k <= len; k++) begin
                mem[base+k] = $urandom;
                is_pay[base+k] = 1'b1;
                exp_q.push_back(mem[base+k]);
            end
            beats += len;
        end
        mem[slots[npk]*8] = {8'($urandom), 24'hFFFFFF};
        head = 24'(slots[0] * 32);
    endtask

    task automatic set_chop(input bit en, input int win, input int gap);
        chop_en = en; chop_win_log = CHOP_W'(win); chop_gap_log = CHOP_W'(gap);
    endtask

    task automatic compare_stream(input string tag);
        int mism = 0;
        check(got_q.size() == exp_q.size(), tag, "payload word count",
              got_q.size(), exp_q.size());
        for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
            if (got_q[i] !== exp_q[i]) begin
                if (mism == 0)
                    check(1'b0, tag, $sformatf("payload word %0d", i), got_q[i], exp_q[i]);
                mism++;
            end
    endtask

    task automatic run_walk(input int npk, input int minlen, input int maxlen,
                            input int ackp, input int rdyp, input string tag,
                            input int exp_busy);
        logic [23:0] head;
        int beats;
        build_chain(npk, minlen, maxlen, head, beats);
        take_snap();
        got_q.delete(); pay_viol = 0; busy_cycles = 0;
        ack_pct = ackp; rdy_pct = rdyp;
        kick(1'b0, head, '0);
        wait_idle();
        compare_stream(tag);
        check(mem_changes() == 0, "R10", "walk left memory unchanged", mem_changes(), 0);
        check(pay_viol == 0, "R5", "no payload read while word waits", pay_viol, 0);
        if (exp_busy >= 0)
            check(busy_cycles == beats, tag, "busy cycles vs words moved", busy_cycles, beats);
    endtask

    function automatic int clear_cycles(input int n, input bit en, input int w, input int g);
        if (n == 0) return 0;
        if (!en) return n;
        return n + (1 << g) * ((n - 1) >> w);
    endfunction

    task automatic run_clear(input int aw, input int n, input int ackp,
                             input bit timed, input string tag);
        int bad = 0;
        fill_random();
        take_snap();
        got_q.delete(); busy_cycles = 0;
        ack_pct = ackp; rdy_pct = 100;
        kick(1'b1, 24'(aw * 4), CNT_W'(n));
        wait_idle();
        for (int w = 0; w < 256; w++) begin
            logic [31:0] e = snap[w];
            int k = aw - w;
            if (k >= 0 && k < n)
                e = (k == n - 1) ? 32'h00FFFFFF : {8'h00, 24'((aw - k - 1) * 4)};
            if (mem[w] !== e) begin
                if (bad == 0) check(1'b0, "R6", $sformatf("table word %0d", w), mem[w], e);
                bad++;
            end
        end
        check(bad == 0, "R6", "table mismatches", bad, 0);
        check(got_q.size() == 0, "R10", "clear mode sent no output", got_q.size(), 0);
        if (timed) begin
            int e = clear_cycles(n, chop_en, int'(chop_win_log), int'(chop_gap_log));
            check(busy_cycles == e, tag, "clear busy cycles", busy_cycles, e);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        check(1'b0, "ALL", "watchdog expired", 0, 1);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h1D2A_77C3));
        fill_random();
        repeat (3) @(negedge clk);
        #1;
        check(busy == 1'b0, "R1", "busy in reset", busy, 0);
        check(mem_req == 1'b0, "R1", "mem_req in reset", mem_req, 0);
        check(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk); #2;
        check(busy == 1'b0 && mem_req == 1'b0, "R1", "quiet after reset", {busy, mem_req}, 0);

        set_chop(1'b0, 0, 0);
        // R3: terminator as first header -> one read, no output
        run_walk(0, 0, 0, 100, 100, "R3", 1);
        // R4: zero-length packets only
        run_walk(4, 0, 0, 100, 100, "R4", 1);
        // R7: full-rate single packet of 8 words
        run_walk(1, 7, 7, 100, 100, "R7", 1);
        run_walk(5, 1, 6, 100, 100, "R7", 1);
        // R2: content with thinned ack
        run_walk(6, 0, 7, 50, 100, "R2", -1);
        // R5: heavy backpressure
        run_walk(6, 1, 7, 100, 25, "R5", -1);

        // R9: start while busy is ignored
        begin
            logic [23:0] head;
            int beats;
            build_chain(5, 2, 5, head, beats);
            take_snap();
            got_q.delete(); pay_viol = 0;
            ack_pct = 100; rdy_pct = 40;
            kick(1'b0, head, '0);
            #2;
            check(busy == 1'b1, "R9", "busy after accepted start", busy, 1);
            kick(1'b1, 24'h000100, CNT_W'(5));
            wait_idle();
            compare_stream("R9");
            check(mem_changes() == 0, "R9", "ignored clear start wrote nothing",
                  mem_changes(), 0);
        end

        // R6 clear mode
        run_clear(100, 1, 100, 1'b1, "R7");
        run_clear(60, 5, 100, 1'b1, "R7");
        run_clear(80, 0, 100, 1'b1, "R6");
        run_clear(200, 17, 60, 1'b0, "R6");

        // R8 chopping
        set_chop(1'b1, 1, 2);
        run_clear(50, 6, 100, 1'b1, "R8");
        set_chop(1'b1, 0, 0);
        run_clear(90, 7, 100, 1'b1, "R8");
        set_chop(1'b1, 2, 1);
        run_clear(120, 11, 100, 1'b1, "R8");
        set_chop(1'b1, 1, 1);
        run_walk(4, 1, 5, 100, 100, "R8", -1);

        // Random mix
        for (int r = 0; r < 8; r++) begin
            set_chop($urandom_range(1), $urandom_range(2), $urandom_range(2));
            run_walk($urandom_range(12, 1), 0, 7, $urandom_range(100, 40),
                     $urandom_range(100, 30), "R2", -1);
        end
        for (int r = 0; r < 4; r++) begin
            int n = $urandom_range(30, 1);
            set_chop($urandom_range(1), $urandom_range(2), $urandom_range(2));
            run_clear($urandom_range(250, n + 1), n, $urandom_range(100, 40), 1'b0, "R6");
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule